// File: doc/BRIEF.md
# Signed Add-Shift Multiplier

A sequential multiplier for two's-complement operands. A multiplicand and a multiplier, each 4 bits wide, are captured when `start_i` is sampled high in idle. The result is an 8-bit two's-complement product. A double-width accumulator keeps the running partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. Each iteration tests the accumulator's least significant bit. If that bit is 1, the multiplicand is combined into the upper half. The whole accumulator is then shifted right by one place.

The shift is arithmetic. The sign of the running partial product enters the top bit. That sign is taken from a one-bit-wider sign-extended adder result, not from the carry-out. The last iteration tests the multiplier's sign bit. When that bit is 1, the multiplicand is subtracted instead of added, which gives the negative weight of a two's-complement top bit.

After exactly four iterations, `done_o` pulses for one cycle. The product then stays on `product_o` until the next accepted start.

Top module: `signed_shift_mul`

## Requirements
- R1: While `rst_ni` is low and after its release, `product_o` is 0 and `done_o` is 0 until an operation completes.
- R2: In idle with `start_i` low, the block stays idle: `done_o` stays 0 and `product_o` keeps its value.
- R3: For every pair of 4-bit two's-complement operands, the product read while `done_o` is high equals their 8-bit two's-complement product.
- R4: Multiplicand 4'b1000 (-8) times multiplier 4'b0110 (+6) yields 8'b1101_0000 (-48).
- R5: `done_o` first reads high after the (W+k+1)-th rising edge, counting from and including the edge that samples `start_i`. Here W=4 and k is the number of 1 bits in the multiplier. Each 1 bit costs one extra add cycle before its shift.
- R6: `done_o` is high for exactly one cycle per operation. The block then returns to idle.
- R7: `start_i` and operand changes while an operation is in progress are ignored and do not affect the result.
- R8: After `done_o`, `product_o` holds the result until the next accepted `start_i`, whatever the operand inputs do.
- R9: When the multiplier sign bit (bit 3) is 1, the final step subtracts the multiplicand. The sign comes from the 5-bit sign-extended result, not the carry-out. Examples: (-8)*(-8) = 8'h40, (-1)*(+1) = 8'hFF, (+7)*(-8) = 8'hC8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a multiply when idle |
| mcand_i | input | 4 | Multiplicand, two's complement |
| mplier_i | input | 4 | Multiplier, two's complement |
| product_o | output | 8 | Product, two's complement |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 256 operand pairs and then random pairs. This exposes two likely bugs:
- A logical shift instead of an arithmetic one would give positive results for negative products.
- Adding instead of subtracting at the sign step would give results off by 16 times the multiplicand for every negative multiplier.

Edge operands stress the sign extension:
- -8 times -8 exercises a 5-bit intermediate result.
- -1 times +1 exercises the same.
- A design that took the sign from the carry-out would flip the top bits on these pairs.

Every operation is also timed and checked for the following:
- a wrong iteration count;
- an add that skips its shift;
- a stretched done pulse;
- a restart triggered by a stray start mid-operation.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/smul_addsub.sv
// Sign-extended W+1 bit adder/subtracter: res = a +/- b
module smul_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W:0]   res_o
);
  logic [W:0] a_ext, b_ext, b_op;

  always_comb begin
    a_ext = {a_i[W-1], a_i};
    b_ext = {b_i[W-1], b_i};
    b_op  = b_ext ^ {(W+1){sub_i}};
    res_o = a_ext + b_op + {{W{1'b0}}, sub_i};
  end
endmodule

// File: rtl/smul_acc.sv
// Accumulator: upper half = partial product, lower half = multiplier bits.
// ext_q is the sign of the partial product beyond the upper half.
module smul_acc #(
  parameter int W = 4,
  localparam int AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          add_i,
  input  logic          shift_i,
  input  logic [W-1:0]  mplier_i,
  input  logic [W:0]    sum_i,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_q;
  logic          ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (load_i) begin
      acc_q <= {{W{1'b0}}, mplier_i};
      ext_q <= 1'b0;
    end else if (add_i) begin
      acc_q[AW-1:W] <= sum_i[W-1:0];
      ext_q         <= sum_i[W];
    end else if (shift_i) begin
      acc_q <= {ext_q, acc_q[AW-1:1]};
    end
  end

  assign acc_o = acc_q;

  AST_LOAD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q[AW-1:W] == '0) && (acc_q[W-1:0] == $past(mplier_i))); // R3

  AST_ADD_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !load_i) |=> $stable(acc_q[W-1:0])); // R3

  AST_SHIFT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(add_i) && shift_i && !load_i && !add_i)
      |=> acc_q[AW-1] == $past(sum_i[W], 2)); // R9
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 4,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic lsb_i,
  output logic load_o,
  output logic add_o,
  output logic sub_o,
  output logic shift_o,
  output logic done_o,
  output logic busy_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  ctrl_st_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic last;

  assign last = (cnt_q == LAST);

  always_comb begin
    st_d    = st_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    sub_o   = 1'b0;
    shift_o = 1'b0;
    done_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = ST_EVAL;
      end
      ST_EVAL: begin
        if (lsb_i) begin
          add_o = 1'b1;
          sub_o = last;  // sign bit carries negative weight
          st_d  = ST_SHIFT;
        end else begin
          shift_o = 1'b1;
          st_d    = last ? ST_DONE : ST_EVAL;
        end
      end
      ST_SHIFT: begin
        shift_o = 1'b1;
        st_d    = last ? ST_DONE : ST_EVAL;
      end
      ST_DONE: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o)       cnt_q <= '0;
      else if (shift_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = (st_q == ST_EVAL) || (st_q == ST_SHIFT);

  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_o); // R7

  AST_ADD_THEN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_o |=> (shift_o && !add_o)); // R5
endmodule

// File: rtl/signed_shift_mul.sv
module signed_shift_mul #(
  parameter int W = 4,
  localparam int AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic [AW-1:0] product_o,
  output logic          done_o
);
  logic          load, add, sub, shift, busy;
  logic [W-1:0]  mcand_q;
  logic [W:0]    sum;
  logic [AW-1:0] acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcand_q <= '0;
    else if (load) mcand_q <= mcand_i;
  end

  smul_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .lsb_i   (acc[0]),
    .load_o  (load),
    .add_o   (add),
    .sub_o   (sub),
    .shift_o (shift),
    .done_o  (done_o),
    .busy_o  (busy)
  );

  smul_addsub #(.W(W)) u_addsub (
    .a_i   (acc[AW-1:W]),
    .b_i   (mcand_q),
    .sub_i (sub),
    .res_o (sum)
  );

  smul_acc #(.W(W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .add_i    (add),
    .shift_i  (shift),
    .mplier_i (mplier_i),
    .sum_i    (sum),
    .acc_o    (acc)
  );

  assign product_o = acc;

  AST_PRODUCT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(product_o)); // R8

  AST_MCAND_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(mcand_q)); // R7
endmodule

// File: tb/tb_signed_shift_mul.sv
module tb_signed_shift_mul;
  localparam int W  = 4;
  localparam int AW = 2 * W;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic [AW-1:0] product;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  signed_shift_mul #(.W(W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .product_o (product),
    .done_o    (done)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act cycles=%0d exp <= %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [AW-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [AW-1:0] ae, be;
    ae = {{W{a[W-1]}}, a};
    be = {{W{b[W-1]}}, b};
    return ae * be;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // One multiply; optional stray start mid-run (R7), then checks R3/R5/R6/R8
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit stray, input string req);
    int n;
    logic [AW-1:0] got;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
      start = 1'b0;
      if (stray && n == 2) begin
        start = 1'b1; mcand = ~a; mplier = b ^ 4'h5;
      end else if (n >= 2) begin
        mcand = ~a; mplier = ~b;
      end
    end while (!done && n < 40);
    start = 1'b0;
    got = product;
    check(got == exp_prod(a, b), req, got, exp_prod(a, b));
    check(n == 1 + W + $countones(b), "R5 latency", n, 1 + W + $countones(b));
    if (stray) check(got == exp_prod(a, b), "R7 stray start", got, exp_prod(a, b));
    @(negedge clk);
    check(!done, "R6 done one cycle", done, 0);
    mcand = $urandom(); mplier = $urandom();
    @(negedge clk);
    check(product == got && !done, "R8 hold", product, got);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(product == '0 && !done, "R1 in reset", {product, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(product == '0 && !done, "R1 after release", {product, done}, 0);

    // R2: idle, start low, inputs moving
    for (int i = 0; i < 10; i++) begin
      mcand = $urandom(); mplier = $urandom();
      @(negedge clk);
      check(!done && product == '0, "R2 idle hold", {product, done}, 0);
    end

    run_op(4'b1000, 4'b0110, 1'b0, "R4 -8x6");
    check(product == 8'hD0, "R4 value", product, 8'hD0);

    run_op(4'b1000, 4'b1000, 1'b0, "R9 -8x-8");
    check(product == 8'h40, "R9 +64", product, 8'h40);
    run_op(4'b0001, 4'b1111, 1'b0, "R9 1x-1");
    check(product == 8'hFF, "R9 -1", product, 8'hFF);
    run_op(4'b0111, 4'b1000, 1'b0, "R9 7x-8");
    check(product == 8'hC8, "R9 -56", product, 8'hC8);
    run_op(4'b1111, 4'b1111, 1'b0, "R9 -1x-1");
    check(product == 8'h01, "R9 +1", product, 8'h01);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(W'(a), W'(b), 1'b0, "R3 exhaustive");

    for (int i = 0; i < 200; i++)
      run_op(W'($urandom()), W'($urandom()), 1'b1, "R3 random");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule